// File: doc/BRIEF.md
# Power Management Register Bank

This block is a bank of power-management control and status words behind a plain 32-bit register bus. The bus has an address, a write enable, a read strobe, write data and read data. Only a sparse set of aligned word offsets inside a 14-bit window is populated. Each populated word loads its own value on reset. Each one stores whatever is written to it and returns it unchanged. Status words have no hardware source, so they read back like any other word.

Two control words also trigger system actions. The power-down control word at offset 0x0200 raises a shutdown request when it is written with bit 16 cleared. The software reset word at offset 0x0400 raises a reset request when it is written with bit 0 set. A power-down write that keeps bit 16 set is then tested as a software reset write: if its bit 0 is set, it raises the reset request. Each request is a one-cycle pulse in the cycle after the write. Software uses the bank as a scratch and configuration space, and the surrounding chip reacts to the two pulses.

The populated map is as follows:
- Power-down control at 0x0200.
- Software reset at 0x0400.
- `N_INFO` information words from 0x0800, spaced 4 bytes apart.
- `N_OPT` domain option words from 0x1000, spaced 4 bytes apart.
- For each of `N_CORE` cores c, a configuration word at 0x2000+0x80*c and a status word 4 bytes above it.
- A hold-control word at 0x330C.

Top module: `pwr_regbank`

## Requirements
- R1: After reset each word holds its own reset value, and rdata, shutdown_req and reset_req are 0. The reset values are:
  - power-down control: 0x00010000
  - software reset: 0
  - information words: 0
  - domain option words: 0xFFFFFFFF
  - core configuration words: 0x00000003
  - core status words: 0x00030003
  - hold-control word: 0x00005200
- R2: A write to a populated offset stores all 32 bits, and a later read returns them unchanged. This includes the core status words.
- R3: A read strobe with address A loads rdata on that clock edge, so rdata is valid one cycle after the strobe. When no read strobe is given, rdata keeps its value.
- R4: A read of an offset that matches no populated word returns 0. Any address whose two low bits are not zero counts as unmatched.
- R5: A write to an unmatched offset, including an unaligned one, changes no stored word and raises no request.
- R6: A write to 0x0200 with bit 16 clear drives shutdown_req high for exactly the next cycle, and the written value is still stored.
- R7: A write to 0x0400 with bit 0 set drives reset_req high for exactly the next cycle. A write to 0x0400 with bit 0 clear raises no request.
- R8: A write to 0x0200 with bit 16 set raises no shutdown request. If its bit 0 is set, it raises reset_req for the next cycle; if its bit 0 is clear, it raises no request at all.
- R9: When a read and a write to the same offset fall in the same cycle, the read returns the value held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write enable |
| addr | input | 14 | Byte offset of the word accessed |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| shutdown_req | output | 1 | One-cycle shutdown request |
| reset_req | output | 1 | One-cycle system reset request |

## Verification
A full sweep of every populated offset after reset separates a wrong per-word reset value from a decode that lands on the wrong word. Readback runs with alternating-bit, all-ones, all-zeros and walking patterns, which expose dropped or swapped data bits. Holes, out-of-window and unaligned addresses are used for both reads and writes, and a second sweep after the stray writes shows that no word was corrupted. The power-down word is written with all four combinations of bits 16 and 0, which separates the shutdown path, the fall-through reset path and the quiet case. The software reset word is written with bit 0 set and with bit 0 clear.

// File: rtl/pwr_regbank_pkg.sv
// Shared constants and map functions for the power management register bank.
// Assumes a word-aligned map; slot order: power-down, software reset,
// information words, domain options, core config/status pairs, hold control.
package pwr_regbank_pkg;

    localparam logic [31:0] PD_OFF      = 32'h0000_0200;
    localparam logic [31:0] SW_OFF      = 32'h0000_0400;
    localparam logic [31:0] INFO_BASE   = 32'h0000_0800;
    localparam logic [31:0] OPT_BASE    = 32'h0000_1000;
    localparam logic [31:0] CORE_BASE   = 32'h0000_2000;
    localparam logic [31:0] CORE_STRIDE = 32'h0000_0080;
    localparam logic [31:0] HOLD_OFF    = 32'h0000_330C;

    localparam int PD_KEEP_BIT = 16;
    localparam int SW_TRIG_BIT = 0;

    localparam logic [31:0] PD_RST   = 32'h0001_0000;
    localparam logic [31:0] OPT_RST  = 32'hFFFF_FFFF;
    localparam logic [31:0] CFG_RST  = 32'h0000_0003;
    localparam logic [31:0] STS_RST  = 32'h0003_0003;
    localparam logic [31:0] HOLD_RST = 32'h0000_5200;

    // Byte offset of slot i for the given group sizes.
    function automatic logic [31:0] slot_offset(int i, int ni, int no, int nc);
        int b_opt, b_core, j;
        b_opt  = 2 + ni;
        b_core = b_opt + no;
        if (i == 0)                 return PD_OFF;
        else if (i == 1)            return SW_OFF;
        else if (i < b_opt)         return INFO_BASE + 32'(4 * (i - 2));
        else if (i < b_core)        return OPT_BASE + 32'(4 * (i - b_opt));
        else if (i < b_core + 2*nc) begin
            j = i - b_core;
            return CORE_BASE + CORE_STRIDE * 32'(j / 2) + 32'(4 * (j % 2));
        end
        else                        return HOLD_OFF;
    endfunction

    // Reset value of slot i for the given group sizes.
    function automatic logic [31:0] slot_reset(int i, int ni, int no, int nc);
        int b_opt, b_core;
        b_opt  = 2 + ni;
        b_core = b_opt + no;
        if (i == 0)                 return PD_RST;
        else if (i < b_opt)         return 32'h0;
        else if (i < b_core)        return OPT_RST;
        else if (i < b_core + 2*nc) return ((i - b_core) % 2 == 0) ? CFG_RST : STS_RST;
        else                        return HOLD_RST;
    endfunction

endpackage

// File: rtl/pwr_regbank_decode.sv
// Address decoder: maps a byte offset to a slot index.
// Assumes every populated offset is word aligned, so an unaligned address
// never matches. Also flags the two request-bearing offsets.
module pwr_regbank_decode
    import pwr_regbank_pkg::*;
#(
    parameter int ADDR_W = 14,
    parameter int N_INFO = 8,
    parameter int N_OPT  = 16,
    parameter int N_CORE = 2,
    parameter int NREG   = 2 + N_INFO + N_OPT + 2*N_CORE + 1,
    parameter int IDX_W  = $clog2(NREG)
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic [IDX_W-1:0]  idx,
    output logic              sel_pd,
    output logic              sel_sw
);

    logic [31:0] addr_ext;
    assign addr_ext = 32'(addr);

    // Compare the address against every slot offset.
    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int i = 0; i < NREG; i++) begin
            if (addr_ext == slot_offset(i, N_INFO, N_OPT, N_CORE)) begin
                hit = 1'b1;
                idx = IDX_W'(i);
            end
        end
    end

    // Flag the two offsets that carry side effects.
    always_comb begin
        sel_pd = (addr_ext == PD_OFF);
        sel_sw = (addr_ext == SW_OFF);
    end

endmodule

// File: rtl/pwr_regbank_word.sv
// One storage word with its own reset value.
// Assumes a synchronous active-low reset; a write loads all bits.
module pwr_regbank_word #(
    parameter int              DATA_W  = 32,
    parameter logic [DATA_W-1:0] RST_VAL = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [DATA_W-1:0] d,
    output logic [DATA_W-1:0] q
);

    // Hold the word; load the reset value or the write data.
    always_ff @(posedge clk) begin
        if (!rst_n)  q <= RST_VAL;
        else if (we) q <= d;
    end

endmodule

// File: rtl/pwr_regbank_rdport.sv
// Registered read port: selects the addressed word, or zero on a miss.
// Assumes the word array is sampled before any same-cycle write lands,
// so a read that collides with a write returns the old value.
module pwr_regbank_rdport #(
    parameter int DATA_W = 32,
    parameter int NREG   = 31,
    parameter int IDX_W  = $clog2(NREG)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        rd_en,
    input  logic                        hit,
    input  logic [IDX_W-1:0]            idx,
    input  logic [NREG-1:0][DATA_W-1:0] words,
    output logic [DATA_W-1:0]           rdata
);

    logic [DATA_W-1:0] sel_word;

    // Pick the addressed word, or zero for an unmatched offset.
    always_comb begin
        sel_word = '0;
        for (int i = 0; i < NREG; i++) begin
            if (hit && idx == IDX_W'(i)) sel_word = words[i];
        end
    end

    // Capture on a read strobe; otherwise hold the last value.
    always_ff @(posedge clk) begin
        if (!rst_n)     rdata <= '0;
        else if (rd_en) rdata <= sel_word;
    end

endmodule

// File: rtl/pwr_regbank_req.sv
// Request pulse generator for shutdown and software reset.
// Assumes wr_en qualifies the write. The pulses are registered, so each one
// lasts a single cycle per qualifying write.
module pwr_regbank_req (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic sel_pd,
    input  logic sel_sw,
    input  logic keep_bit,
    input  logic trig_bit,
    output logic shutdown_req,
    output logic reset_req
);

    logic sd_next, rs_next;

    // Power-down with the keep bit clear shuts down; with it set, the write
    // falls through to the software-reset test.
    always_comb begin
        sd_next = wr_en && sel_pd && !keep_bit;
        rs_next = wr_en && trig_bit && (sel_sw || (sel_pd && keep_bit));
    end

    // Register the requests as one-cycle pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shutdown_req <= 1'b0;
            reset_req    <= 1'b0;
        end else begin
            shutdown_req <= sd_next;
            reset_req    <= rs_next;
        end
    end

endmodule

// File: rtl/pwr_regbank.sv
// Top of the power management register bank.
// Assumes full-word accesses on a simple bus. Combines the decoder, one
// storage word per slot, the registered read port and the request pulses.
module pwr_regbank
    import pwr_regbank_pkg::*;
#(
    parameter int ADDR_W = 14,
    parameter int DATA_W = 32,
    parameter int N_INFO = 8,
    parameter int N_OPT  = 16,
    parameter int N_CORE = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              shutdown_req,
    output logic              reset_req
);

    localparam int NREG  = 2 + N_INFO + N_OPT + 2*N_CORE + 1;
    localparam int IDX_W = $clog2(NREG);

    logic                        hit, sel_pd, sel_sw;
    logic [IDX_W-1:0]            idx;
    logic [NREG-1:0][DATA_W-1:0] words;

    pwr_regbank_decode #(
        .ADDR_W(ADDR_W), .N_INFO(N_INFO), .N_OPT(N_OPT),
        .N_CORE(N_CORE), .NREG(NREG), .IDX_W(IDX_W)
    ) u_decode (
        .addr(addr), .hit(hit), .idx(idx), .sel_pd(sel_pd), .sel_sw(sel_sw)
    );

    for (genvar g = 0; g < NREG; g++) begin : g_word
        pwr_regbank_word #(
            .DATA_W (DATA_W),
            .RST_VAL(DATA_W'(slot_reset(g, N_INFO, N_OPT, N_CORE)))
        ) u_word (
            .clk(clk),
            .rst_n(rst_n),
            .we(wr_en && hit && idx == IDX_W'(g)),
            .d(wdata),
            .q(words[g])
        );
    end

    pwr_regbank_rdport #(
        .DATA_W(DATA_W), .NREG(NREG), .IDX_W(IDX_W)
    ) u_rdport (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .hit(hit), .idx(idx),
        .words(words), .rdata(rdata)
    );

    pwr_regbank_req u_req (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en),
        .sel_pd(sel_pd), .sel_sw(sel_sw),
        .keep_bit(wdata[PD_KEEP_BIT]), .trig_bit(wdata[SW_TRIG_BIT]),
        .shutdown_req(shutdown_req), .reset_req(reset_req)
    );

endmodule

// File: rtl/pwr_regbank_chk.sv
// Protocol checker for the power management register bank, bound to the top.
// Relates bus activity in one cycle to request pulses and read data in the next.
module pwr_regbank_chk #(
    parameter int ADDR_W = 14,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_en,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wdata,
    input logic [DATA_W-1:0] rdata,
    input logic              shutdown_req,
    input logic              reset_req
);

    localparam logic [ADDR_W-1:0] A_PD = ADDR_W'(32'h200);
    localparam logic [ADDR_W-1:0] A_SW = ADDR_W'(32'h400);

    AST_SHUTDOWN_ON_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_PD && !wdata[16]) |=> shutdown_req) else $error("AST_SHUTDOWN_ON_CLEAR"); // R6

    AST_SHUTDOWN_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        shutdown_req |-> $past(wr_en && addr == A_PD && !wdata[16])) else $error("AST_SHUTDOWN_CAUSE"); // R6

    AST_SWRESET_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_SW && wdata[0]) |=> reset_req) else $error("AST_SWRESET_PULSE"); // R7

    AST_PD_FALLTHROUGH: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_PD && wdata[16] && wdata[0]) |=> (reset_req && !shutdown_req)) else $error("AST_PD_FALLTHROUGH"); // R8

    AST_UNALIGNED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr[1:0] != 2'b00) |=> rdata == '0) else $error("AST_UNALIGNED_READ_ZERO"); // R4

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata)) else $error("AST_RDATA_HOLD"); // R3

endmodule

bind pwr_regbank pwr_regbank_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .shutdown_req(shutdown_req),
    .reset_req(reset_req)
);

// File: tb/pwr_regbank_bench.sv
`timescale 1ns/100ps
// Scoreboard bench: read tasks push expected words, a monitor pops and compares.
module pwr_regbank_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [13:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        shutdown_req, reset_req;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 0;

    logic [31:0] mdl [int];
    logic [31:0] exp_q [$];
    string       tag_q [$];
    logic        rd_q = 1'b0;

    always #2.5 clk = ~clk;

    pwr_regbank u_pwr_regbank (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .shutdown_req(shutdown_req),
        .reset_req(reset_req)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] expect_rd(input int a);
        if (mdl.exists(a)) return mdl[a];
        return 32'h0;
    endfunction

    // Monitor: remember a strobe at the edge, compare at the following negedge.
    always @(posedge clk) rd_q <= rd_en;
    always @(negedge clk) begin
        if (rd_q && exp_q.size() > 0) chk(tag_q.pop_front(), rdata, exp_q.pop_front());
    end

    task automatic rd(input int a, input string tag);
        @(negedge clk);
        rd_en = 1'b1; wr_en = 1'b0; addr = 14'(a);
        exp_q.push_back(expect_rd(a)); tag_q.push_back(tag);
    endtask

    task automatic idle();
        @(negedge clk);
        rd_en = 1'b0; wr_en = 1'b0; addr = 14'h1000;
    endtask

    task automatic wr(input int a, input logic [31:0] d, input logic sd, input logic rs, input string tag);
        @(negedge clk);
        rd_en = 1'b0; wr_en = 1'b1; addr = 14'(a); wdata = d;
        if (mdl.exists(a)) mdl[a] = d;
        @(negedge clk);
        wr_en = 1'b0;
        chk({tag, " shutdown"}, 32'(shutdown_req), 32'(sd));
        chk({tag, " reset"}, 32'(reset_req), 32'(rs));
        @(negedge clk);
        chk({tag, " pulse end"}, 32'({shutdown_req, reset_req}), 32'h0);
    endtask

    task automatic sweep(input string tag);
        foreach (mdl[k]) rd(k, tag);
        idle();
    endtask

    initial begin
        // Expected map from R1.
        mdl[32'h200] = 32'h0001_0000;
        mdl[32'h400] = 32'h0;
        for (int i = 0; i < 8; i++)  mdl[32'h800 + 4*i]  = 32'h0;
        for (int i = 0; i < 16; i++) mdl[32'h1000 + 4*i] = 32'hFFFF_FFFF;
        for (int c = 0; c < 2; c++) begin
            mdl[32'h2000 + 32'h80*c]     = 32'h0000_0003;
            mdl[32'h2000 + 32'h80*c + 4] = 32'h0003_0003;
        end
        mdl[32'h330C] = 32'h0000_5200;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 rdata after reset", rdata, 32'h0);
        chk("R1 requests after reset", 32'({shutdown_req, reset_req}), 32'h0);

        sweep("R1 reset value");

        // R4: holes, out of window, unaligned.
        rd(32'h0004, "R4 hole"); rd(32'h0202, "R4 unaligned");
        rd(32'h1040, "R4 past options"); rd(32'h2008, "R4 core gap");
        rd(32'h3D0C, "R4 past hold"); rd(32'h3FFC, "R4 top"); rd(32'h330D, "R4 unaligned hold");
        idle();

        // R2: data patterns.
        wr(32'h800, 32'hA5A5_5A5A, 0, 0, "R2 write");
        wr(32'h81C, 32'h5A5A_A5A5, 0, 0, "R2 write");
        wr(32'h1000, 32'h0000_0000, 0, 0, "R2 write");
        wr(32'h103C, 32'h1234_5678, 0, 0, "R2 write");
        wr(32'h2084, 32'h8000_0001, 0, 0, "R2 status write");
        wr(32'h2004, 32'h0000_0100, 0, 0, "R2 status write");
        wr(32'h330C, 32'hFFFF_FFFF, 0, 0, "R2 write");
        rd(32'h800, "R2 readback"); rd(32'h81C, "R2 readback");
        rd(32'h1000, "R2 readback"); rd(32'h103C, "R2 readback");
        rd(32'h2084, "R2 status readback"); rd(32'h2004, "R2 status readback");
        rd(32'h330C, "R2 readback");
        idle();

        // R5: stray writes.
        wr(32'h0008, 32'hDEAD_BEEF, 0, 0, "R5 hole write");
        wr(32'h1040, 32'hDEAD_BEEF, 0, 0, "R5 past options write");
        wr(32'h0401, 32'h0000_0001, 0, 0, "R5 unaligned swreset write");
        wr(32'h0201, 32'h0000_0000, 0, 0, "R5 unaligned powerdown write");
        sweep("R5 no corruption");

        // R6, R8: power-down word combinations.
        wr(32'h200, 32'h0000_0000, 1, 0, "R6 shutdown");
        rd(32'h200, "R6 stored"); idle();
        wr(32'h200, 32'h0000_0001, 1, 0, "R6 shutdown bit0 set");
        wr(32'h200, 32'h0001_0001, 0, 1, "R8 fall-through reset");
        wr(32'h200, 32'h0001_0000, 0, 0, "R8 quiet");
        rd(32'h200, "R8 stored"); idle();

        // R7: software reset word.
        wr(32'h400, 32'h0000_0001, 0, 1, "R7 reset");
        wr(32'h400, 32'h0000_0002, 0, 0, "R7 bit0 clear");
        rd(32'h400, "R7 stored"); idle();

        // R9: read and write the same word together.
        @(negedge clk);
        rd_en = 1'b1; wr_en = 1'b1; addr = 14'h804; wdata = 32'hC0DE_0099;
        exp_q.push_back(mdl[32'h804]); tag_q.push_back("R9 old value");
        mdl[32'h804] = 32'hC0DE_0099;
        rd(32'h804, "R9 new value");
        idle();

        // R3: rdata holds while no strobe.
        rd(32'h330C, "R3 read");
        idle(); idle(); idle();
        chk("R3 hold", rdata, mdl[32'h330C]);

        idle(); idle();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_vec++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule